// File: doc/BRIEF.md
# Redundant-Stage Code Combiner for a Pipelined Converter

This block is the digital back end of a nine-stage pipelined analog-to-digital converter. Stages one to eight each resolve a two-bit decision, and one of those bits is spare range that absorbs comparator error in the stage. The ninth stage is a plain two-bit flash. Adjacent stages work on opposite halves of the sampling clock, so the decisions for one sample reach the block spread over four and a half cycles, each stage half a cycle behind its predecessor.

The combiner catches each stage code on the clock edge at which that stage produces it, and holds it in a chain of registers on alternating rising and falling edges until all nine codes of a sample meet on one rising edge. An adder then weights the codes so that each stage overlaps its successor by one bit. The result is limited to the 10-bit range and registered, with a flag that marks which output words come from flagged samples. After the fixed latency one result leaves per clock.

A build option selects how a stage code of 3 from the first eight stages is read: folded to 2, which is the default, or taken at face value, in which case the sum can pass the top code and is clamped.

Top module: `adc_redundant_corrector`

## Requirements
- R1: While rst_n is low, out_valid and out_code are 0 without waiting for a clock edge. A sample is only reported if its in_valid was captured on a rising edge after rst_n returned high; samples in flight when reset was asserted are dropped.
- R2: A sample whose in_valid is high at rising edge n gives out_valid high after rising edge n+5; out_valid is low after edge n+5 when in_valid was low at edge n.
- R3: Samples flagged on consecutive rising edges give results on consecutive cycles, in sampling order, with no gaps.
- R4: stage_codes[2k+1:2k] carries the code of stage k+1 (k = 0..8). For the sample taken at rising edge n, the code of stage k+1 is captured at half-edge 2n+k, counting rising edges as even half-edges and the falling edge after rising edge n as half-edge 2n+1; odd-numbered stages are therefore caught on rising edges and even-numbered ones on falling edges.
- R5: The result is the sum over stages 1..8 of code times 2^(9-stage), plus the stage-9 code, presented as unsigned offset binary on out_code.
- R6: With SAT_CODE3 = 1, a code of 3 from any of stages 1..8 is counted as 2, so the sum never passes 1023.
- R7: With SAT_CODE3 = 0, codes of 3 from stages 1..8 are counted as 3, and any sum above 1023 is reported as 1023.
- R8: The stage-9 code counts with its full value 0..3 and alone sets the least significant bit of an unclamped result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; both edges are used for capture |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Marks the sample taken at this rising edge |
| stage_codes | input | 18 | Stage decisions, two bits per stage, stage 1 in the low bits |
| out_code | output | 10 | Corrected offset-binary result |
| out_valid | output | 1 | out_code belongs to a flagged sample |

## Verification
The assertions take as given that every stage code is settled across the edge on which its stage is captured and that in_valid is settled across each rising edge; the output-lowest-bit and clamp checks only mean anything when the nine codes meeting at the adder belong to one sample. The stimulus keeps to this by changing the odd-stage codes and in_valid one nanosecond after a falling edge and the even-stage codes one nanosecond after a rising edge, each time loading the code of the sample that the next matching edge belongs to. Reset is raised and dropped only between edges, so the warm-up count that the valid check relies on starts at a clean edge.

// File: rtl/adc_corr_pkg.sv
`timescale 1ns/100ps
package adc_corr_pkg;

   typedef logic [1:0] stage_code_t;

   // Largest code a redundant stage is allowed to deliver.
   localparam stage_code_t CODE_TOP_LEGAL = 2'd2;

   // Binary weight exponent of stage idx (0-based) among n stages.
   function automatic int unsigned weight_exp(int unsigned idx, int unsigned n);
      return (idx == n - 1) ? 0 : (n - 1 - idx);
   endfunction

   // Half-edge index 0 is a rising edge; odd indices are falling edges.
   function automatic bit on_rising(int unsigned half_idx);
      return (half_idx % 2) == 0;
   endfunction

endpackage

// File: rtl/adc_corr_stage_delay.sv
`timescale 1ns/100ps
module adc_corr_stage_delay
   import adc_corr_pkg::*;
#(
   parameter int unsigned START_HALF = 0,
   parameter int unsigned END_HALF   = 8
) (
   input  logic        clk,
   input  logic        rst_n,
   input  stage_code_t d,
   output stage_code_t q
);

   localparam int unsigned DEPTH = END_HALF - START_HALF + 1;

   if (END_HALF < START_HALF) begin : g_bad_window
      $error("stage delay window ends before it starts");
   end

   // One register per half cycle, edge chosen by the half-edge index.
   for (genvar k = 0; k < DEPTH; k++) begin : hop
      localparam int unsigned HALF_IDX = START_HALF + k;
      stage_code_t src;
      stage_code_t r;

      if (k == 0) begin : g_head
         assign src = d;
      end else begin : g_link
         assign src = hop[k-1].r;
      end

      if (on_rising(HALF_IDX)) begin : g_rise
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= src;
         end
      end else begin : g_fall
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n) r <= '0;
            else        r <= src;
         end
      end
   end

   assign q = hop[DEPTH-1].r;

endmodule

// File: rtl/adc_corr_valid_delay.sv
`timescale 1ns/100ps
module adc_corr_valid_delay #(
   parameter int unsigned DEPTH = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("valid delay needs at least one register");
   end

   logic [DEPTH-1:0] sh;

   if (DEPTH == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= d;
      end
   end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[DEPTH-2:0], d};
      end
   end

   assign q = sh[DEPTH-1];

endmodule

// File: rtl/adc_corr_overlap_sum.sv
`timescale 1ns/100ps
module adc_corr_overlap_sum
   import adc_corr_pkg::*;
#(
   parameter int unsigned NUM_STAGES = 9,
   parameter int unsigned OUT_BITS   = 10,
   parameter bit          SAT_CODE3  = 1'b1
) (
   input  logic [2*NUM_STAGES-1:0] codes,
   output logic [OUT_BITS-1:0]     code,
   output logic                    clamp_hit
);

   // Worst case 3*2^N - 3 fits in N+2 bits.
   localparam int unsigned SUM_W    = NUM_STAGES + 2;
   localparam int unsigned CODE_MAX = (1 << OUT_BITS) - 1;

   if (OUT_BITS != NUM_STAGES + 1) begin : g_bad_width
      $error("result width must be one more than the stage count");
   end

   logic [NUM_STAGES-1:0][SUM_W-1:0] parts;
   logic [SUM_W-1:0]                 total;

   for (genvar g = 0; g < NUM_STAGES; g++) begin : stg
      localparam int unsigned WEXP = weight_exp(g, NUM_STAGES);
      stage_code_t raw;
      stage_code_t eff;

      assign raw = codes[2*g +: 2];

      if ((g < NUM_STAGES - 1) && SAT_CODE3) begin : g_fold
         assign eff = (raw == 2'd3) ? CODE_TOP_LEGAL : raw;
      end else begin : g_pass
         assign eff = raw;
      end

      assign parts[g] = SUM_W'(eff) << WEXP;
   end

   always_comb begin
      total = '0;
      for (int k = 0; k < NUM_STAGES; k++) begin
         total = total + parts[k];
      end
   end

   assign clamp_hit = (total > SUM_W'(CODE_MAX));
   assign code      = clamp_hit ? OUT_BITS'(CODE_MAX) : total[OUT_BITS-1:0];

endmodule

// File: rtl/adc_redundant_corrector.sv
`timescale 1ns/100ps
module adc_redundant_corrector
   import adc_corr_pkg::*;
#(
   parameter int unsigned NUM_STAGES = 9,
   parameter int unsigned OUT_BITS   = 10,
   parameter bit          SAT_CODE3  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic [2*NUM_STAGES-1:0] stage_codes,
   output logic [OUT_BITS-1:0]     out_code,
   output logic                    out_valid
);

   localparam int unsigned LAST_HALF = NUM_STAGES - 1;
   localparam int unsigned ALIGN_CYC = LAST_HALF / 2;
   localparam int unsigned LATENCY   = ALIGN_CYC + 1;
   localparam int unsigned CODE_MAX  = (1 << OUT_BITS) - 1;
   localparam int unsigned WARM_W    = $clog2(LATENCY + 2) + 1;

   if (NUM_STAGES < 3) begin : g_bad_count
      $error("at least three stages are needed");
   end
   if (NUM_STAGES % 2 == 0) begin : g_bad_parity
      $error("stage count must be odd so the last stage lands on a rising edge");
   end
   if (OUT_BITS != NUM_STAGES + 1) begin : g_bad_out
      $error("result width must be one more than the stage count");
   end

   logic [2*NUM_STAGES-1:0] aligned;
   logic                    valid_aligned;
   logic [OUT_BITS-1:0]     sum_code;
   logic                    clamp_hit;
   logic [OUT_BITS-1:0]     out_code_q;
   logic                    out_valid_q;

   // Stage g+1 is caught at half-edge g and walked forward to LAST_HALF.
   for (genvar g = 0; g < NUM_STAGES; g++) begin : lane
      adc_corr_stage_delay #(
         .START_HALF (g),
         .END_HALF   (LAST_HALF)
      ) u_delay (
         .clk   (clk),
         .rst_n (rst_n),
         .d     (stage_codes[2*g +: 2]),
         .q     (aligned[2*g +: 2])
      );
   end

   adc_corr_valid_delay #(
      .DEPTH (ALIGN_CYC + 1)
   ) u_vdelay (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (in_valid),
      .q     (valid_aligned)
   );

   adc_corr_overlap_sum #(
      .NUM_STAGES (NUM_STAGES),
      .OUT_BITS   (OUT_BITS),
      .SAT_CODE3  (SAT_CODE3)
   ) u_sum (
      .codes     (aligned),
      .code      (sum_code),
      .clamp_hit (clamp_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_code_q  <= '0;
         out_valid_q <= 1'b0;
      end else begin
         out_code_q  <= sum_code;
         out_valid_q <= valid_aligned;
      end
   end

   assign out_code  = out_code_q;
   assign out_valid = out_valid_q;

   // Rising edges seen since reset, saturating; feeds the warm-up check.
   logic [WARM_W-1:0] warm_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                warm_cnt <= '0;
      else if (warm_cnt < WARM_W'(LATENCY + 1))  warm_cnt <= warm_cnt + 1'b1;
   end

   // R1
   valid_after_warm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_q |-> (warm_cnt >= WARM_W'(LATENCY + 1)));

   // R7
   clamp_to_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clamp_hit) |-> (out_code_q == OUT_BITS'(CODE_MAX)));

   // R8
   final_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_q && !$past(clamp_hit)) |->
         (out_code_q[0] == $past(aligned[2*(NUM_STAGES-1)])));

   if (SAT_CODE3) begin : g_sat_chk
      // R6
      sat_no_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !clamp_hit);
   end

endmodule

// File: tb/adc_redundant_corrector_test.sv
`timescale 1ns/100ps
module adc_redundant_corrector_test;

   localparam int NV    = 10;
   localparam int SMAX  = 64;
   localparam int LAT   = 5;
   localparam int RST_P = 50;
   localparam int END_P = 70;

   typedef struct packed {
      logic [17:0] codes;   // stage 9 in bits 17:16 ... stage 1 in bits 1:0
      logic [9:0]  expv;
   } vec_t;

   localparam vec_t VECS [NV] = '{
      {18'b00_00_00_00_00_00_00_00_00, 10'd0},    // R5 floor
      {18'b01_01_01_01_01_01_01_01_01, 10'd511},  // R5 midscale
      {18'b11_10_10_10_10_10_10_10_10, 10'd1023}, // R5 R8 top
      {18'b00_00_00_00_00_00_00_00_11, 10'd512},  // R6 first stage 3 -> 2
      {18'b11_11_11_11_11_11_11_11_11, 10'd1023}, // R6 all 3
      {18'b00_00_00_00_00_00_00_00_10, 10'd512},  // R5
      {18'b10_01_00_10_01_00_10_00_01, 10'd420},  // R5 mixed
      {18'b11_01_01_01_01_01_01_01_00, 10'd257},  // R8 final 3
      {18'b00_00_00_00_00_00_00_10_10, 10'd768},  // R5
      {18'b00_00_00_00_00_00_00_10_01, 10'd512}   // R5 redundant form of 512
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [17:0] stage_codes = '0;
   logic [9:0]  out_code, out_code_raw;
   logic        out_valid, out_valid_raw;

   int n_tests = 0;
   int n_fail  = 0;
   int pcnt    = 0;

   logic [17:0] s_codes [SMAX];
   logic        s_vld   [SMAX];
   logic [9:0]  s_exp   [SMAX];

   always #2.5 clk = ~clk;

   adc_redundant_corrector uut (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
      .stage_codes (stage_codes), .out_code (out_code), .out_valid (out_valid)
   );

   adc_redundant_corrector #(.SAT_CODE3 (1'b0)) uut_raw (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
      .stage_codes (stage_codes), .out_code (out_code_raw), .out_valid (out_valid_raw)
   );

   function automatic logic [1:0] pick(int s, int stage);
      if (s < 0 || s >= SMAX) return 2'd0;
      return s_codes[s][2*(stage-1) +: 2];
   endfunction

   function automatic logic pick_vld(int s);
      if (s < 0 || s >= SMAX) return 1'b0;
      return s_vld[s];
   endfunction

   // Reference from the weighting rule, independent of the design.
   function automatic logic [9:0] ref_code(logic [17:0] c, bit sat);
      int sum = 0;
      for (int i = 1; i <= 9; i++) begin
         int v = int'(c[2*(i-1) +: 2]);
         if (i < 9) begin
            if (sat && v == 3) v = 2;
            sum += v << (9 - i);
         end else begin
            sum += v;
         end
      end
      if (sum > 1023) sum = 1023;
      return 10'(sum);
   endfunction

   task automatic check(string req, int act, int expv);
      n_tests++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s at edge %0d: actual %0d expected %0d", req, pcnt, act, expv);
      end
   endtask

   task automatic check_reset();
      check("R1 valid in reset", int'(out_valid), 0);
      check("R1 code in reset", int'(out_code), 0);
      check("R1 raw valid in reset", int'(out_valid_raw), 0);
   endtask

   task automatic check_outputs(int s);
      logic ev;
      ev = pick_vld(s);
      if (s >= RST_P - 4 && s <= RST_P + 2) ev = 1'b0;   // R1 flushed by reset
      check("R2 R3 out_valid", int'(out_valid), int'(ev));
      check("R2 R3 raw out_valid", int'(out_valid_raw), int'(ev));
      if (ev) begin
         check("R4 R5 R6 R8 out_code", int'(out_code), int'(s_exp[s]));
         check("R7 raw out_code", int'(out_code_raw), int'(ref_code(s_codes[s], 1'b0)));
      end
   endtask

   // Odd stages and in_valid feed the coming rising edge p.
   task automatic drive_rise(int p);
      for (int i = 1; i <= 9; i += 2) stage_codes[2*(i-1) +: 2] = pick(p - (i-1)/2, i);
      in_valid = pick_vld(p);
   endtask

   // Even stages feed the falling edge right after rising edge p.
   task automatic drive_fall(int p);
      for (int i = 2; i <= 9; i += 2) stage_codes[2*(i-1) +: 2] = pick(p - (i-2)/2, i);
   endtask

   initial begin
      for (int s = 0; s < SMAX; s++) begin
         s_codes[s] = '0; s_vld[s] = 1'b0; s_exp[s] = '0;
      end
      // Back-to-back table walk (R3)
      for (int v = 0; v < NV; v++) begin
         s_codes[10+v] = VECS[v].codes; s_vld[10+v] = 1'b1; s_exp[10+v] = VECS[v].expv;
      end
      // Unflagged junk samples (R2)
      s_codes[20] = '1; s_codes[21] = '1;
      // Reversed table, every other sample flagged
      for (int v = 0; v < NV; v++) begin
         s_codes[22+v] = VECS[NV-1-v].codes;
         s_vld[22+v]   = (v % 2 == 0);
         s_exp[22+v]   = VECS[NV-1-v].expv;
      end
      // Stream across a mid-run reset (R1)
      for (int k = 0; k < 20; k++) begin
         s_codes[40+k] = VECS[k % NV].codes; s_vld[40+k] = 1'b1; s_exp[40+k] = VECS[k % NV].expv;
      end

      drive_rise(1);
      while (pcnt < END_P) begin
         @(posedge clk);
         pcnt++;
         #1;
         if (pcnt <= 3 || (pcnt > RST_P && pcnt <= RST_P + 2)) check_reset();
         else check_outputs(pcnt - LAT);
         if (pcnt == RST_P) begin
            rst_n = 1'b0;
            #0.5;
            check_reset();   // R1 asynchronous clear
         end
         if (pcnt == 3 || pcnt == RST_P + 2) rst_n = 1'b1;
         drive_fall(pcnt);
         @(negedge clk);
         #1;
         drive_rise(pcnt + 1);
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_tests++;
      n_fail++;
      $display("FAIL R2 watchdog: actual edge %0d expected %0d", pcnt, END_P);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule